// File: doc/BRIEF.md
# Multiplexed Host Register Port

This block gives a host processor access to a small bank of configuration bytes and a set of read-only error-flag bytes over one 8-bit bus. The same bus carries both register indices and register contents. A separate select line tells the block which of the two the host is presenting. The host's chip select, direction and address/data lines are not related to the internal pixel clock. The block samples them through a two-stage synchronizer and acts on a completed access only when the synchronized chip select returns high.

A host access has two kinds of phase. In an index phase the host writes the register number into the block. One or more data phases follow, and each one either writes the indexed configuration byte or reads back the indexed byte. The index is held between accesses, so one index phase can serve any number of data phases. The block does not drive the bus pins itself. It produces the read value and an output-enable, and the pad ring uses them to build the tristate driver. The host pins carry no back-pressure: the host owns the timing and only has to hold its lines steady for the synchronizer.

Top module: `hostbus_regport`

## Requirements
- R1: While rst_n is low, and after it is released, every configuration byte on cfg_q is 0x00 and the held register index is 0.
- R2: bus_oe is 1 exactly when cs_n is 0 and rd_wr is 1 (1 means a host read), with no clock delay. It is 0 when cs_n is 1 or when rd_wr is 0.
- R3: An access made with cs_n low, rd_wr low and ad_sel high (1 means an index phase) loads the bus byte as the new register index when the access completes.
- R4: An access made with cs_n low, rd_wr low and ad_sel low writes the bus byte into the configuration byte at the held index. The write takes effect no sooner than the second and no later than the third rising clock edge after cs_n rises. Configuration byte i sits at cfg_q bits [8i+7:8i].
- R5: The register index does not change during data-phase writes or reads, so repeated data phases all reach the same register.
- R6: While cs_n is low and rd_wr is high, bus_out carries the byte at the held index. Indices 0 to NCFG-1 read the configuration bytes. Indices FLAG_BASE to FLAG_BASE+NFLAG-1 read the flag_in bytes, with flag j at flag_in bits [8j+7:8j].
- R7: Indices outside both ranges read as 0x00. A write to such an index, or to a flag index, leaves every configuration byte unchanged.
- R8: An access made with rd_wr high changes neither the configuration bytes nor the register index, whatever the level of ad_sel.
- R9: Changes on bus_in, rd_wr and ad_sel while cs_n stays high have no effect on the configuration bytes or on the register index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Host chip select, active low, asynchronous |
| rd_wr | input | 1 | Host direction, 1 = read, 0 = write, asynchronous |
| ad_sel | input | 1 | 1 = index phase, 0 = data phase, asynchronous |
| bus_in | input | 8 | Byte received from the host bus pins |
| bus_out | output | 8 | Byte to drive onto the host bus pins |
| bus_oe | output | 1 | Output enable for the bus pin drivers |
| flag_in | input | 8*NFLAG | Error-flag bytes presented for reading |
| cfg_q | output | 8*NCFG | Configuration bytes held by the port |

## Verification
The bench stresses four behaviours, each of which a faulty design would show in a specific way.

- Index persistence. The bench makes several data phases after a single index phase. A design that reloads the index on data phases would write or read the wrong byte.
- Read cycles. The bench issues read cycles with ad_sel high. A design that decodes an index phase without looking at direction would move the index to whatever the host left on the bus.
- Illegal targets. Writes aimed at flag or unimplemented indices must not land. A design that wraps or truncates the index would corrupt a configuration byte.
- Idle bus activity. The bench toggles bus_in and the control lines while cs_n is high, and changes the configuration only at the commit point. A design that acts on unsynchronized or idle lines would show configuration changes during the quiet stretch.

// File: rtl/hrp_pkg.sv
package hrp_pkg;
  localparam int BUS_W = 8;

  typedef logic [BUS_W-1:0] bus_t;

  // host pins as seen after synchronization
  typedef struct packed {
    logic cs_n;
    logic rd_wr;
    logic ad_sel;
    bus_t bus;
  } host_ctl_t;

  localparam int CTL_W = $bits(host_ctl_t);

  // idle bus: deselected, read direction so nothing is committed
  localparam host_ctl_t CTL_IDLE = '{cs_n: 1'b1, rd_wr: 1'b1, ad_sel: 1'b0, bus: '0};

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_INDEX = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_READ  = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/hrp_sync.sv
module hrp_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/hrp_cmd.sv
module hrp_cmd
  import hrp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  host_ctl_t ctl_s,
  output acc_kind_e cmd_kind,
  output bus_t      cmd_data,
  output logic      cs_high
);
  host_ctl_t held_q;
  logic      was_low_q;

  // capture the last settled view of the access while selected
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q    <= CTL_IDLE;
      was_low_q <= 1'b0;
    end else begin
      was_low_q <= ~ctl_s.cs_n;
      if (!ctl_s.cs_n) held_q <= ctl_s;
    end
  end

  logic release_now;
  assign release_now = ctl_s.cs_n & was_low_q;
  assign cs_high     = ctl_s.cs_n;
  assign cmd_data    = held_q.bus;

  always_comb begin
    cmd_kind = ACC_NONE;
    if (release_now) begin
      if (held_q.rd_wr)       cmd_kind = ACC_READ;
      else if (held_q.ad_sel) cmd_kind = ACC_INDEX;
      else                    cmd_kind = ACC_WRITE;
    end
  end
endmodule

// File: rtl/hrp_regfile.sv
module hrp_regfile
  import hrp_pkg::*;
#(
  parameter int NCFG      = 4,
  parameter int NFLAG     = 2,
  parameter int FLAG_BASE = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  acc_kind_e               cmd_kind,
  input  bus_t                    cmd_data,
  input  logic [NFLAG*BUS_W-1:0]  flag_in,
  output bus_t                    addr_q,
  output logic [NCFG*BUS_W-1:0]   cfg_q,
  output bus_t                    rd_q
);
  localparam int FLAG_END = FLAG_BASE + NFLAG;

  // index register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     addr_q <= '0;
    else if (cmd_kind == ACC_INDEX) addr_q <= cmd_data;
  end

  // configuration bytes, one write decoder each
  for (genvar g = 0; g < NCFG; g++) begin : g_cfg
    logic hit;
    assign hit = (cmd_kind == ACC_WRITE) && (int'(addr_q) == g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cfg_q[g*BUS_W +: BUS_W] <= '0;
      else if (hit) cfg_q[g*BUS_W +: BUS_W] <= cmd_data;
    end
  end

  // read selection, registered toward the pads
  bus_t rd_d;
  always_comb begin
    rd_d = '0;
    for (int i = 0; i < NCFG; i++)
      if (int'(addr_q) == i) rd_d = cfg_q[i*BUS_W +: BUS_W];
    for (int j = 0; j < NFLAG; j++)
      if (int'(addr_q) == FLAG_BASE + j) rd_d = flag_in[j*BUS_W +: BUS_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  if (FLAG_END > 256) begin : g_bad_map
    initial $error("flag window exceeds the 8-bit index space");
  end
endmodule

// File: rtl/hostbus_regport.sv
module hostbus_regport
  import hrp_pkg::*;
#(
  parameter int NCFG      = 4,
  parameter int NFLAG     = 2,
  parameter int FLAG_BASE = 16,
  parameter int SYNC_STG  = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cs_n,
  input  logic                   rd_wr,
  input  logic                   ad_sel,
  input  logic [7:0]             bus_in,
  output logic [7:0]             bus_out,
  output logic                   bus_oe,
  input  logic [NFLAG*8-1:0]     flag_in,
  output logic [NCFG*8-1:0]      cfg_q
);
  host_ctl_t ctl_raw, ctl_s;
  acc_kind_e cmd_kind;
  bus_t      cmd_data;
  bus_t      addr_q;
  bus_t      rd_q;
  logic      cs_high;

  assign ctl_raw = '{cs_n: cs_n, rd_wr: rd_wr, ad_sel: ad_sel, bus: bus_in};

  hrp_sync #(
    .W      (CTL_W),
    .STAGES (SYNC_STG),
    .RST_VAL(CTL_IDLE)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (ctl_raw),
    .q    (ctl_s)
  );

  hrp_cmd u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl_s   (ctl_s),
    .cmd_kind(cmd_kind),
    .cmd_data(cmd_data),
    .cs_high (cs_high)
  );

  hrp_regfile #(
    .NCFG     (NCFG),
    .NFLAG    (NFLAG),
    .FLAG_BASE(FLAG_BASE)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_kind(cmd_kind),
    .cmd_data(cmd_data),
    .flag_in (flag_in),
    .addr_q  (addr_q),
    .cfg_q   (cfg_q),
    .rd_q    (rd_q)
  );

  // pad enable follows the raw pins so the bus is released at once
  assign bus_oe  = ~cs_n & rd_wr;
  assign bus_out = rd_q;
endmodule

// File: rtl/hostbus_regport_chk.sv
module hostbus_regport_chk
  import hrp_pkg::*;
#(
  parameter int NCFG      = 4,
  parameter int NFLAG     = 2,
  parameter int FLAG_BASE = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cs_n,
  input logic                 rd_wr,
  input logic                 bus_oe,
  input logic [7:0]           bus_out,
  input logic [NCFG*8-1:0]    cfg_q,
  input bus_t                 addr_q,
  input acc_kind_e            cmd_kind,
  input logic                 cs_high
);
  logic unimpl;
  assign unimpl = (int'(addr_q) >= NCFG) &&
                  !((int'(addr_q) >= FLAG_BASE) && (int'(addr_q) < FLAG_BASE + NFLAG));

  AST_OE_OFF_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !rd_wr) |-> !bus_oe);                                      // R2
  AST_OE_OFF_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !bus_oe);                                                   // R2
  AST_COMMIT_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_kind != ACC_NONE) |-> cs_high);                                 // R4
  AST_CFG_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q != $past(cfg_q)) |-> ($past(cmd_kind) == ACC_WRITE));         // R8
  AST_INDEX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_kind != ACC_INDEX) |=> $stable(addr_q));                        // R5
  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (unimpl && $stable(addr_q)) |=> (bus_out == 8'h00));                 // R7
endmodule

bind hostbus_regport hostbus_regport_chk #(
  .NCFG     (NCFG),
  .NFLAG    (NFLAG),
  .FLAG_BASE(FLAG_BASE)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cs_n    (cs_n),
  .rd_wr   (rd_wr),
  .bus_oe  (bus_oe),
  .bus_out (bus_out),
  .cfg_q   (cfg_q),
  .addr_q  (addr_q),
  .cmd_kind(cmd_kind),
  .cs_high (cs_high)
);

// File: tb/hostbus_regport_tb_top.sv
module hostbus_regport_tb_top;
  localparam int NCFG      = 4;
  localparam int NFLAG     = 2;
  localparam int FLAG_BASE = 16;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                cs_n = 1'b1;
  logic                rd_wr = 1'b1;
  logic                ad_sel = 1'b0;
  logic [7:0]          bus_in = 8'h00;
  logic [7:0]          bus_out;
  logic                bus_oe;
  logic [NFLAG*8-1:0]  flag_in = 16'hC3_5A;
  logic [NCFG*8-1:0]   cfg_q;

  int n_chk = 0;
  int n_fail = 0;
  int quiet = 0;
  bit done = 0;

  // reference state
  logic [7:0] cfg_m [NCFG];
  int         idx_m;

  always #2 clk = ~clk; // 250 MHz

  hostbus_regport #(.NCFG(NCFG), .NFLAG(NFLAG), .FLAG_BASE(FLAG_BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_wr(rd_wr), .ad_sel(ad_sel),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .flag_in(flag_in), .cfg_q(cfg_q)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [NCFG*8-1:0] cfg_pack();
    logic [NCFG*8-1:0] v;
    for (int i = 0; i < NCFG; i++) v[i*8 +: 8] = cfg_m[i];
    return v;
  endfunction

  function automatic logic [7:0] exp_read();
    if (idx_m < NCFG) return cfg_m[idx_m];
    if (idx_m >= FLAG_BASE && idx_m < FLAG_BASE + NFLAG)
      return flag_in[(idx_m - FLAG_BASE)*8 +: 8];
    return 8'h00;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NCFG; i++) cfg_m[i] = 8'h00;
    idx_m = 0;
  endtask

  // quiet counter: cycles since the host deselected
  always @(posedge clk) begin
    if (!rst_n || !cs_n) quiet <= 0;
    else                 quiet <= quiet + 1;
  end

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 oe", {31'd0, bus_oe}, {31'd0, (!cs_n && rd_wr)});
      if (quiet >= 4) chk("R4/R7/R8/R9 cfg", cfg_q, cfg_pack());
    end
  end

  // one host access: ad/rw/data, optional read check
  task automatic host(input logic ad, input logic rw, input logic [7:0] d, input string req);
    @(negedge clk);
    ad_sel = ad; rd_wr = rw; bus_in = d;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (5) @(negedge clk);
    if (rw) chk(req, bus_out, exp_read());
    cs_n = 1'b1;
    if (!rw && ad)  idx_m = d;
    if (!rw && !ad && idx_m < NCFG) cfg_m[idx_m] = d;
    repeat (2) @(negedge clk);
    rd_wr = 1'b1; ad_sel = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1 cfg in reset", cfg_q, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 cfg after reset", cfg_q, '0);
    chk("R2 oe idle", {31'd0, bus_oe}, 32'd0);
    host(1'b0, 1'b1, 8'h00, "R1 read index 0");

    host(1'b1, 1'b0, 8'h02, "R3 index 2");
    host(1'b0, 1'b0, 8'hA5, "R4 write A5");
    host(1'b0, 1'b1, 8'h00, "R6 read idx2");
    host(1'b0, 1'b0, 8'h3C, "R5 second write");
    host(1'b0, 1'b1, 8'h00, "R5 read after rewrite");
    host(1'b0, 1'b1, 8'h00, "R5 repeated read");
    chk("R4 cfg byte 2", cfg_q[23:16], 8'h3C);

    host(1'b1, 1'b0, 8'h00, "R3 index 0");
    host(1'b0, 1'b0, 8'h11, "R4 write idx0");
    host(1'b1, 1'b0, 8'h03, "R3 index 3");
    host(1'b0, 1'b0, 8'hFF, "R4 write idx3");
    host(1'b1, 1'b0, 8'h01, "R3 index 1");
    host(1'b0, 1'b0, 8'h80, "R4 write idx1");
    host(1'b0, 1'b1, 8'h00, "R6 read idx1");

    host(1'b1, 1'b0, FLAG_BASE[7:0], "R3 flag index");
    host(1'b0, 1'b1, 8'h00, "R6 read flag0");
    host(1'b0, 1'b0, 8'h55, "R7 write to flag");
    host(1'b0, 1'b1, 8'h00, "R7 flag unchanged");
    host(1'b1, 1'b0, FLAG_BASE[7:0] + 8'd1, "R3 flag1 index");
    host(1'b0, 1'b1, 8'h00, "R6 read flag1");
    flag_in = 16'h0F_F0;
    repeat (3) @(negedge clk);
    host(1'b0, 1'b1, 8'h00, "R6 read flag1 updated");

    host(1'b1, 1'b0, 8'h07, "R3 index unimpl");
    host(1'b0, 1'b1, 8'h00, "R7 unimpl reads zero");
    host(1'b0, 1'b0, 8'hEE, "R7 write unimpl");
    host(1'b0, 1'b1, 8'h00, "R7 unimpl still zero");
    host(1'b1, 1'b0, 8'h84, "R7 high index");
    host(1'b0, 1'b0, 8'h9D, "R7 write high index");

    host(1'b1, 1'b0, 8'h02, "R3 back to idx2");
    host(1'b1, 1'b1, 8'h01, "R8 read with ad high");
    host(1'b0, 1'b1, 8'h00, "R8 index kept");

    // R9: activity with chip select high
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      bus_in = 8'h30 + 8'(k); rd_wr = k[0]; ad_sel = k[1];
    end
    rd_wr = 1'b1; ad_sel = 1'b0;
    repeat (6) @(negedge clk);
    chk("R9 cfg unchanged", cfg_q, cfg_pack());
    host(1'b0, 1'b1, 8'h00, "R9 index unchanged");

    // R1: reset mid run
    @(negedge clk); rst_n = 1'b0; model_reset();
    repeat (2) @(negedge clk);
    chk("R1 cfg cleared", cfg_q, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    host(1'b0, 1'b1, 8'h00, "R1 index cleared");
    finish_run();
  end
endmodule